// File: doc/BRIEF.md
# I2C Master Command Sequencer

A single-master I2C transaction engine that executes one command at a time. Software writes a 32-bit command word carrying a byte count, the transfer direction, and flags for start, stop and NAK-on-last. Setting the run bit together with the master bit launches the command. Transmit bytes come from a 32-bit data word, lowest byte first. Received bytes are packed back into that same word, lowest byte first.

A command that has no stop flag leaves SCL held low, and the bus stays owned by the engine. The next command then carries on the same transaction, with or without a repeated start. Bit timing comes from an external strobe: each bus bit takes four strobe steps.

If the target does not acknowledge, the engine freezes with SCL low and sets sticky flags. It stays frozen until software pulses the clear-NAK input. If SDA reads low while the engine is releasing it during a transmitted bit, the engine has lost arbitration. It aborts, releases both lines and reports a master-loss flag.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset, both line drivers are released, and run, all flags, bus-busy, clock-busy and the data word are all zero.
- R2: A command write is accepted only when bit 29 (run) and bit 17 (master) are both set, the engine is not running and it is not frozen by a NAK. Run then stays high until the command completes, including any stop. Run then clears and the done flag is set. Accepting a command clears the done and master-loss flags.
- R3: The command fields are: byte count in bits 15:0, transmit direction in bit 16 (1 = transmit), start in bit 19, stop in bit 20 and NAK-on-last in bit 25. Bit 21 (hold clock) is accepted but adds nothing, because every command without stop already ends with SCL held low.
- R4: A transmit sends data-word byte k mod 4 as the k-th byte of the command, starting from byte 0 (bits 7:0). Each byte goes out most significant bit first.
- R5: A start condition is produced only when the start flag of the current command is set. A command without it continues the open transaction, with no start condition on the bus.
- R6: A stop condition follows the last byte only when the stop flag is set. Without it, the engine ends with SCL driven low and bus-busy still high, until the next command runs.
- R7: A NAK after a transmitted byte does four things: it sets got-NAK and the no-ack flag, clears run, holds SCL low and ignores every command. A pulse on the clear-NAK input clears both flags and lets commands run again.
- R8: A receive ACKs every byte. With NAK-on-last set, the final byte is NAKed instead. Received byte k is stored in data-word byte k mod 4, and the other bytes keep their values.
- R9: While run is high, command writes and data-word writes have no effect.
- R10: Bus-busy rises with a start condition and falls after a stop condition. Clock-busy is high only while the engine is producing a start, a data bit or a stop.
- R11: If SDA is sampled low during a transmitted 1 bit, the engine loses arbitration. It releases both lines, clears run and bus-busy, and sets the master-loss flag.
- R12: A command with run set but master clear is ignored: run stays low and no bus activity occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timing strobe, one step per quarter bit |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word |
| data_wr | input | 1 | Data word write strobe |
| data_wdata | input | DATA_W | Data word to transmit |
| nak_clr | input | 1 | Clear-NAK pulse that releases a frozen engine |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| run | output | 1 | Command in progress |
| data_rdata | output | DATA_W | Data word, including received bytes |
| got_nak | output | 1 | Sticky NAK status |
| noack_irq | output | 1 | No-acknowledge interrupt flag |
| mloss_irq | output | 1 | Arbitration-loss interrupt flag |
| done_irq | output | 1 | Command completed |
| bus_busy | output | 1 | Bus owned between start and stop |
| clkgen_busy | output | 1 | Engine actively clocking SCL |

## Verification
The bench builds the block with DATA_W = 32, CNT_W = 16 and TICK_DIV = 1, and supplies its own strobe on every second clock, so one bus bit lasts eight clocks. The four-lane data word makes a six-byte transmit wrap back to lane 0. Three chained commands (address, then two reads) exercise the continuation rules, including ACK versus NAK on the last byte and lane overwrite. The full 16-bit count allows a zero-count command that emits only start and stop.

// File: rtl/i2c_cmd_seq_pkg.sv
package i2c_cmd_seq_pkg;
   // command word bit positions
   localparam int CB_TX      = 16;
   localparam int CB_MST     = 17;
   localparam int CB_START   = 19;
   localparam int CB_STOP    = 20;
   localparam int CB_HOLD    = 21;
   localparam int CB_NAKLAST = 25;
   localparam int CB_RUN     = 29;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_BIT,
      ST_STOP,
      ST_HOLD,
      ST_HALT
   } seq_st_e;
endpackage

// File: rtl/i2c_seq_phase.sv
module i2c_seq_phase #(
   parameter int TICK_DIV = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       clr,
   output logic [1:0] ph,
   output logic       unit_end
);
   logic step;

   generate
      if (TICK_DIV <= 1) begin : g_direct
         assign step = tick;
      end else begin : g_div
         localparam int DW = $clog2(TICK_DIV);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (clr) begin
               div_q <= '0;
            end else if (tick) begin
               div_q <= (div_q == DW'(TICK_DIV - 1)) ? '0 : div_q + 1'b1;
            end
         end
         assign step = tick && (div_q == DW'(TICK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= 2'd0;
      end else if (clr) begin
         ph <= 2'd0;
      end else if (step) begin
         ph <= ph + 2'd1;
      end
   end

   assign unit_end = step && (ph == 2'd3);
endmodule

// File: rtl/i2c_seq_dword.sv
module i2c_seq_dword #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_all,
   input  logic [DATA_W-1:0] wdata,
   input  logic              lane_we,
   input  logic [IDX_W-1:0]  lane_sel,
   input  logic [7:0]        lane_d,
   output logic [DATA_W-1:0] q,
   output logic [7:0]        lane_q
);
   localparam int LANES = DATA_W / 8;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q[l*8 +: 8] <= 8'h00;
            end else if (wr_all) begin
               q[l*8 +: 8] <= wdata[l*8 +: 8];
            end else if (lane_we && (lane_sel == IDX_W'(l))) begin
               q[l*8 +: 8] <= lane_d;
            end
         end
      end
   endgenerate

   assign lane_q = q[lane_sel*8 +: 8];
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
   import i2c_cmd_seq_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 16,
   parameter int TICK_DIV = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              cmd_wr,
   input  logic [31:0]       cmd_wdata,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_wdata,
   input  logic              nak_clr,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              run,
   output logic [DATA_W-1:0] data_rdata,
   output logic              got_nak,
   output logic              noack_irq,
   output logic              mloss_irq,
   output logic              done_irq,
   output logic              bus_busy,
   output logic              clkgen_busy
);
   localparam int LANES = DATA_W / 8;
   localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0 || (LANES & (LANES - 1)) != 0) begin : g_bad_dw
         $error("DATA_W must be a power-of-two number of bytes");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W must lie in 1..16");
      end
   endgenerate

   seq_st_e            st_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [IDX_W-1:0]   idx_q;
   logic [3:0]         bitn_q;
   logic [7:0]         sh_q;
   logic               f_tx, f_stop, f_naklast;
   logic               run_q, nak_q, noack_q, mloss_q, done_q, busy_q;
   logic [1:0]         ph;
   logic               unit_end;
   logic [7:0]         lane_q;
   logic               bitval, accept, data_bit, nak_hit, loss_hit, fin_now;
   logic               ack_drive, lane_we;
   logic [CNT_W-1:0]   cmd_cnt;
   logic               unused_cmd;

   assign cmd_cnt    = cmd_wdata[CNT_W-1:0];
   assign unused_cmd = ^{cmd_wdata[31:30], cmd_wdata[28:26], cmd_wdata[24:22],
                         cmd_wdata[CB_HOLD], cmd_wdata[18], cmd_wdata[15:CNT_W-1]};

   assign accept   = cmd_wr && cmd_wdata[CB_RUN] && cmd_wdata[CB_MST] &&
                     !run_q && (st_q != ST_HALT);
   assign data_bit = !bitn_q[3];
   assign bitval   = lane_q[3'(~bitn_q[2:0])];
   assign nak_hit  = f_tx && sda_i;
   assign loss_hit = f_tx && bitval && !sda_i;
   assign ack_drive = !(f_naklast && (cnt_q == CNT_W'(1)));
   assign lane_we  = unit_end && (st_q == ST_BIT) && !f_tx && (bitn_q == 4'd7);
   assign fin_now  = !accept && unit_end &&
                     (((st_q == ST_START) && (cnt_q == '0)) ||
                      ((st_q == ST_BIT) && !data_bit && !nak_hit && (cnt_q == CNT_W'(1))));

   i2c_seq_phase #(.TICK_DIV(TICK_DIV)) phase_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clr(accept),
      .ph(ph), .unit_end(unit_end)
   );

   i2c_seq_dword #(.DATA_W(DATA_W), .IDX_W(IDX_W)) dword_i (
      .clk(clk), .rst_n(rst_n),
      .wr_all(data_wr && !run_q), .wdata(data_wdata),
      .lane_we(lane_we), .lane_sel(idx_q), .lane_d({sh_q[6:0], sda_i}),
      .q(data_rdata), .lane_q(lane_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cnt_q     <= '0;
         idx_q     <= '0;
         bitn_q    <= 4'd0;
         sh_q      <= 8'h00;
         f_tx      <= 1'b0;
         f_stop    <= 1'b0;
         f_naklast <= 1'b0;
         run_q     <= 1'b0;
         nak_q     <= 1'b0;
         noack_q   <= 1'b0;
         mloss_q   <= 1'b0;
         done_q    <= 1'b0;
         busy_q    <= 1'b0;
      end else if (accept) begin
         cnt_q     <= cmd_cnt;
         idx_q     <= '0;
         bitn_q    <= 4'd0;
         f_tx      <= cmd_wdata[CB_TX];
         f_stop    <= cmd_wdata[CB_STOP];
         f_naklast <= cmd_wdata[CB_NAKLAST];
         done_q    <= 1'b0;
         mloss_q   <= 1'b0;
         run_q     <= 1'b1;
         if (cmd_wdata[CB_START]) begin
            st_q   <= ST_START;
            busy_q <= 1'b1;
         end else if (cmd_cnt != '0) begin
            st_q <= ST_BIT;
         end else if (cmd_wdata[CB_STOP]) begin
            st_q <= ST_STOP;
         end else begin
            st_q   <= ST_HOLD;
            run_q  <= 1'b0;
            done_q <= 1'b1;
         end
      end else begin
         if (nak_clr) begin
            nak_q   <= 1'b0;
            noack_q <= 1'b0;
            if (st_q == ST_HALT) st_q <= ST_HOLD;
         end
         if (unit_end) begin
            case (st_q)
               ST_START: if (cnt_q != '0) st_q <= ST_BIT;
               ST_BIT: begin
                  if (data_bit) begin
                     if (loss_hit) begin
                        st_q    <= ST_IDLE;
                        run_q   <= 1'b0;
                        busy_q  <= 1'b0;
                        mloss_q <= 1'b1;
                     end else begin
                        bitn_q <= bitn_q + 4'd1;
                        if (!f_tx) sh_q <= {sh_q[6:0], sda_i};
                     end
                  end else if (nak_hit) begin
                     st_q    <= ST_HALT;
                     nak_q   <= 1'b1;
                     noack_q <= 1'b1;
                     run_q   <= 1'b0;
                  end else begin
                     cnt_q  <= cnt_q - CNT_W'(1);
                     idx_q  <= idx_q + IDX_W'(1);
                     bitn_q <= 4'd0;
                  end
               end
               ST_STOP: begin
                  st_q   <= ST_IDLE;
                  busy_q <= 1'b0;
                  run_q  <= 1'b0;
                  done_q <= 1'b1;
               end
               default: ;
            endcase
         end
         if (fin_now) begin
            if (f_stop) begin
               st_q <= ST_STOP;
            end else begin
               st_q   <= ST_HOLD;
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      scl_oe = 1'b0;
      sda_oe = 1'b0;
      case (st_q)
         ST_START: begin
            scl_oe = (ph == 2'd0) || (ph == 2'd3);
            sda_oe = ph[1];
         end
         ST_BIT: begin
            scl_oe = !ph[1];
            if (data_bit) sda_oe = f_tx ? !bitval : 1'b0;
            else          sda_oe = f_tx ? 1'b0 : ack_drive;
         end
         ST_STOP: begin
            scl_oe = (ph == 2'd0);
            sda_oe = !ph[1];
         end
         ST_HOLD, ST_HALT: scl_oe = 1'b1;
         default: ;
      endcase
   end

   assign run         = run_q;
   assign got_nak     = nak_q;
   assign noack_irq   = noack_q;
   assign mloss_irq   = mloss_q;
   assign done_irq    = done_q;
   assign bus_busy    = busy_q;
   assign clkgen_busy = (st_q == ST_START) || (st_q == ST_BIT) || (st_q == ST_STOP);
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_wr,
   input logic              run,
   input logic              got_nak,
   input logic              noack_irq,
   input logic              mloss_irq,
   input logic              bus_busy,
   input logic              clkgen_busy,
   input logic              scl_oe,
   input logic              sda_oe,
   input logic              f_tx,
   input logic [DATA_W-1:0] data_rdata
);
   // R2: run can only rise after a command write
   a_r2_run_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> $past(cmd_wr));

   // R7: a NAK raises both flags and drops run
   a_r7_nak_flags: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(got_nak) |-> (noack_irq && !run));

   // R7: while frozen, SCL is held low, SDA is released and nothing is clocked
   a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      got_nak |-> (scl_oe && !sda_oe && !run && !clkgen_busy));

   // R10: the clock generator is active only inside a running command
   a_r10_clk_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      clkgen_busy |-> run);

   // R11: arbitration loss releases the bus
   a_r11_loss_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mloss_irq) |-> (!run && !bus_busy && !scl_oe && !sda_oe));

   // R9: the data word does not move during a running transmit
   a_r9_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && f_tx) |-> $stable(data_rdata));
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk #(.DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .run(run), .got_nak(got_nak),
   .noack_irq(noack_irq), .mloss_irq(mloss_irq), .bus_busy(bus_busy),
   .clkgen_busy(clkgen_busy), .scl_oe(scl_oe), .sda_oe(sda_oe),
   .f_tx(f_tx), .data_rdata(data_rdata)
);

// File: tb/i2c_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module i2c_cmd_seq_tb_top;
   localparam int EV_S = 512;
   localparam int EV_P = 513;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [31:0] cmd_wdata = '0;
   logic        data_wr = 1'b0;
   logic [31:0] data_wdata = '0;
   logic        nak_clr = 1'b0;
   logic        scl_oe, sda_oe, run, got_nak, noack_irq, mloss_irq, done_irq;
   logic        bus_busy, clkgen_busy;
   logic [31:0] data_rdata;

   logic tgt_drive = 1'b0;
   logic force_low = 1'b0;
   logic scl_l, sda_l;
   assign scl_l = !scl_oe;
   assign sda_l = !(sda_oe || tgt_drive || force_low);

   int n_chk = 0;
   int n_fail = 0;
   int exp_q[$];

   // target model state
   bit       mon_en = 1'b1;
   bit       tgt_tx = 1'b0;
   int       nak_at = -1;
   int       bits = 0;
   int       tk = 0;
   logic [7:0] msh = 8'h00;
   logic [7:0] tx_bytes [8];
   logic     p_scl = 1'b1, p_sda = 1'b1;

   always #5 clk = ~clk;
   always @(posedge clk) tick <= !tick;

   i2c_cmd_seq dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
      .data_wr(data_wr), .data_wdata(data_wdata), .nak_clr(nak_clr), .sda_i(sda_l),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .run(run), .data_rdata(data_rdata),
      .got_nak(got_nak), .noack_irq(noack_irq), .mloss_irq(mloss_irq),
      .done_irq(done_irq), .bus_busy(bus_busy), .clkgen_busy(clkgen_busy)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic got_ev(input int e);
      int x;
      if (exp_q.size() == 0) begin
         chk(1'b0, "R5/R6/R9 unexpected bus event", 32'(e), 32'hFFFF_FFFF);
      end else begin
         x = exp_q.pop_front();
         chk(x == e, "R4/R5/R6/R8 bus event", 32'(e), 32'(x));
      end
   endtask

   // monitor and target model
   always @(negedge clk) begin
      if (mon_en) begin
         if (scl_l && p_scl && p_sda && !sda_l) begin
            got_ev(EV_S); bits = 0; tk = 0; tgt_drive = 1'b0;
         end else if (scl_l && p_scl && !p_sda && sda_l) begin
            got_ev(EV_P); bits = 0;
         end else if (scl_l && !p_scl) begin
            if (bits < 8) begin
               msh = {msh[6:0], sda_l}; bits++;
            end else if (bits == 8) begin
               got_ev({23'd0, sda_l, msh}); bits = 9; tk++;
            end
         end else if (!scl_l && p_scl) begin
            if (bits == 9) bits = 0;
            if (bits == 8) tgt_drive = tgt_tx ? 1'b0 : (tk != nak_at);
            else if (bits < 8) tgt_drive = tgt_tx ? !tx_bytes[tk % 8][7 - bits] : 1'b0;
         end
      end
      p_scl = scl_l;
      p_sda = sda_l;
   end

   function automatic logic [31:0] cw(input bit s, input bit p, input bit tx,
                                     input bit nl, input bit m, input int n);
      logic [31:0] w;
      w = '0;
      w[15:0] = 16'(n);
      w[16] = tx; w[17] = m; w[19] = s; w[20] = p; w[25] = nl; w[29] = 1'b1;
      return w;
   endfunction

   task automatic send_cmd(input logic [31:0] w);
      @(negedge clk); cmd_wdata = w; cmd_wr = 1'b1;
      @(negedge clk); cmd_wr = 1'b0;
   endtask

   task automatic put_data(input logic [31:0] d);
      @(negedge clk); data_wdata = d; data_wr = 1'b1;
      @(negedge clk); data_wr = 1'b0;
   endtask

   task automatic wait_idle();
      int g;
      g = 0;
      while (run && g < 5000) begin @(negedge clk); g++; end
      repeat (16) @(negedge clk);
   endtask

   task automatic q_empty(input string req);
      chk(exp_q.size() == 0, req, 32'(exp_q.size()), 32'd0);
   endtask

   initial begin
      #1_500_000;
      chk(1'b0, "watchdog R2", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) tx_bytes[i] = 8'hFF;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!scl_oe && !sda_oe, "R1 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);
      chk(!run && !got_nak && !noack_irq && !mloss_irq && !done_irq && !bus_busy && !clkgen_busy,
          "R1 flags clear", {25'd0, run, got_nak, noack_irq, mloss_irq, done_irq, bus_busy, clkgen_busy}, 32'd0);
      chk(data_rdata == 32'd0, "R1 data word", data_rdata, 32'd0);

      // R4 six-byte transmit wraps through the four lanes; R3 field positions
      put_data(32'h3322_11A0);
      exp_q.push_back(EV_S);
      exp_q.push_back(32'h0A0); exp_q.push_back(32'h011); exp_q.push_back(32'h022);
      exp_q.push_back(32'h033); exp_q.push_back(32'h0A0); exp_q.push_back(32'h011);
      exp_q.push_back(EV_P);
      send_cmd(cw(1, 1, 1, 0, 1, 6));
      chk(run, "R2 run set while active", {31'd0, run}, 32'd1);
      wait_idle();
      q_empty("R4 all bytes seen");
      chk(!run && done_irq && !bus_busy, "R2 completion", {29'd0, run, done_irq, bus_busy}, 32'b010);

      // R6 no stop: ends holding SCL; R9 writes while running are ignored
      put_data(32'hD4C3_B2A0);
      exp_q.push_back(EV_S);
      exp_q.push_back(32'h0A0); exp_q.push_back(32'h0B2);
      exp_q.push_back(32'h0C3); exp_q.push_back(32'h0D4);
      send_cmd(cw(1, 0, 1, 0, 1, 4));
      repeat (20) @(negedge clk);
      chk(clkgen_busy && bus_busy, "R10 busy during transfer", {30'd0, clkgen_busy, bus_busy}, 32'd3);
      put_data(32'hFFFF_FFFF);
      send_cmd(cw(1, 1, 1, 0, 1, 1));
      wait_idle();
      repeat (60) @(negedge clk);
      q_empty("R9 ignored command left no trace");
      chk(data_rdata == 32'hD4C3_B2A0, "R9 data write ignored", data_rdata, 32'hD4C3_B2A0);
      chk(!scl_l && bus_busy && !clkgen_busy, "R6 SCL held low",
          {29'd0, scl_l, bus_busy, clkgen_busy}, 32'b010);

      // R5 continuation without start
      put_data(32'h0000_005A);
      exp_q.push_back(32'h05A); exp_q.push_back(EV_P);
      send_cmd(cw(0, 1, 1, 0, 1, 1));
      wait_idle();
      q_empty("R5 no start on continuation");
      chk(!bus_busy, "R10 bus free after stop", {31'd0, bus_busy}, 32'd0);

      // R8 reads: address, then two chained receive commands
      put_data(32'h0000_00A1);
      exp_q.push_back(EV_S); exp_q.push_back(32'h0A1);
      send_cmd(cw(1, 0, 1, 0, 1, 1));
      wait_idle();
      tx_bytes[0] = 8'hC3; tx_bytes[1] = 8'h5E; tx_bytes[2] = 8'h7F; tx_bytes[3] = 8'hFF;
      tk = 0; tgt_tx = 1'b1; tgt_drive = !tx_bytes[0][7];
      exp_q.push_back(32'h0C3); exp_q.push_back(32'h05E);
      send_cmd(cw(0, 0, 0, 0, 1, 2));
      wait_idle();
      chk(data_rdata == 32'h0000_5EC3, "R8 packed bytes with ACK", data_rdata, 32'h0000_5EC3);
      exp_q.push_back(32'h17F); exp_q.push_back(EV_P);
      send_cmd(cw(0, 1, 0, 1, 1, 1));
      wait_idle();
      tgt_tx = 1'b0; tgt_drive = 1'b0;
      q_empty("R8 last byte NAKed");
      chk(data_rdata == 32'h0000_5E7F, "R8 lane 0 overwritten", data_rdata, 32'h0000_5E7F);

      // R7 NAK freeze
      nak_at = 1;
      put_data(32'h0066_55A0);
      exp_q.push_back(EV_S); exp_q.push_back(32'h0A0); exp_q.push_back(32'h155);
      send_cmd(cw(1, 1, 1, 0, 1, 3));
      wait_idle();
      nak_at = -1;
      chk(got_nak && noack_irq && !run && !scl_l, "R7 frozen after NAK",
          {28'd0, got_nak, noack_irq, run, scl_l}, 32'b1100);
      send_cmd(cw(1, 1, 1, 0, 1, 1));
      repeat (60) @(negedge clk);
      chk(!run && got_nak, "R7 command ignored while frozen", {30'd0, run, got_nak}, 32'b01);
      q_empty("R7 no bus activity while frozen");
      @(negedge clk); nak_clr = 1'b1;
      @(negedge clk); nak_clr = 1'b0;
      chk(!got_nak && !noack_irq, "R7 clear-NAK", {30'd0, got_nak, noack_irq}, 32'd0);
      exp_q.push_back(EV_P);
      send_cmd(cw(0, 1, 1, 0, 1, 0));
      wait_idle();
      q_empty("R7 stop after release");

      // R12 master bit clear
      send_cmd(cw(1, 1, 1, 0, 0, 1));
      repeat (60) @(negedge clk);
      chk(!run, "R12 command without master ignored", {31'd0, run}, 32'd0);
      q_empty("R12 no bus activity");

      // R11 arbitration loss
      mon_en = 1'b0; force_low = 1'b1;
      put_data(32'h0000_00FF);
      send_cmd(cw(1, 1, 1, 0, 1, 1));
      wait_idle();
      chk(mloss_irq && !run && !bus_busy && !clkgen_busy && !done_irq, "R11 master loss",
          {27'd0, mloss_irq, run, bus_busy, clkgen_busy, done_irq}, 32'b10000);
      chk(!scl_oe && !sda_oe, "R11 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);
      force_low = 1'b0;
      repeat (8) @(negedge clk);
      bits = 0; mon_en = 1'b1;

      // R3 zero count with start and stop; R2 accept clears master loss
      exp_q.push_back(EV_S); exp_q.push_back(EV_P);
      send_cmd(cw(1, 1, 1, 0, 1, 0));
      wait_idle();
      q_empty("R3 zero-count transfer");
      chk(done_irq && !mloss_irq, "R2 flags after new command", {30'd0, done_irq, mloss_irq}, 32'b10);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule